// File: doc/BRIEF.md
# Two-Warp Issue Scheduler

This block decides, every clock cycle, which of the warps of a small SIMT core may issue. The default is two warps of eight lanes each, so sixteen threads in total. For each warp it keeps one of three states: ready, stalled or halted. A stalled warp also carries a countdown that models the memory latency after a load or store.

The execute stage drives three request inputs: a stall pulse, a halt pulse and the index of the warp they address. A stall parks that warp for a fixed number of cycles, four by default, and it then rejoins scheduling on its own. A halt takes the warp out of scheduling for good.

The scheduler presents the selected warp index, a flag that tells whether that warp may issue in this cycle, and a done flag. Done rises once every warp has halted. The selection logic looks at the readiness the warps will have after the current edge. Because of this, a stall or halt on the current warp moves issue to another ready warp on the same edge that records the request, with no idle cycle. When all warps are ready, issue rotates between them.

Top module: `warp_sched`

## Requirements
- R1: After reset, every warp is ready, `cur_warp` is 0, `issue_valid` is 1 and `done` is 0.
- R2: A stall request for warp w, sampled at clock edge k, keeps w out of issue for exactly STALL_CYCLES cycles. Warp w is stalled after edges k through k+STALL_CYCLES-1 and ready again after edge k+STALL_CYCLES.
- R3: Once a warp has halted, it never becomes ready or stalled again. Later stall requests to that warp have no effect on it.
- R4: When a stall request and a halt request address the same warp at the same edge, the halt is applied and the stall is dropped.
- R5: When the current warp stalls or halts and another warp is ready, `cur_warp` moves to that warp on the same edge, and `issue_valid` stays 1.
- R6: Whenever every warp is ready, `cur_warp` advances to the next index, wrapping around, on each edge. The first cycle after reset shows warp 0.
- R7: When no warp is ready, `issue_valid` is 0 and `cur_warp` holds its value. Issue resumes on the edge at which some warp becomes ready.
- R8: `done` is 1 only when every warp is halted. It rises on the edge that applies the last halt and stays high.
- R9: A request addressed to a warp other than the current one changes only that warp's state.
- R10: A stall request to a warp that is already stalled reloads its countdown, so the full STALL_CYCLES window starts again from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| stall_req | input | 1 | Stall pulse from the execute stage for the warp in `req_warp` |
| halt_req | input | 1 | Halt pulse from the execute stage for the warp in `req_warp` |
| req_warp | input | WARP_W | Warp addressed by the stall or halt pulse |
| cur_warp | output | WARP_W | Warp selected to issue |
| issue_valid | output | 1 | The selected warp is ready and may issue |
| done | output | 1 | Every warp has halted |

## Verification
Every output is registered, so a request sampled at an edge shows up on `cur_warp`, `issue_valid` and `done` in the cycle that follows that edge, one cycle after the request was driven. A stalled warp's return is due STALL_CYCLES edges after the request. The bench drives each request on the falling edge and samples the outputs shortly after the next rising edge. For every scenario, the bench counts edges from the request and checks the stall windows at their last stalled edge and at their first ready edge.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    W_READY   = 2'd0,
    W_STALLED = 2'd1,
    W_HALTED  = 2'd2
  } warp_state_e;

endpackage

// File: rtl/warp_slot.sv
module warp_slot
  import sched_pkg::*;
#(
  parameter int STALL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_hit,
  input  logic halt_hit,
  output logic ready_q,
  output logic halted_q,
  output logic ready_d,
  output logic halted_d
);

  localparam int CNT_W = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STALL_CYCLES - 1);

  warp_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next state: halt beats stall, halted is terminal
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (state_q != W_HALTED) begin
      if (halt_hit) begin
        state_d = W_HALTED;
      end else if (stall_hit) begin
        state_d = W_STALLED;
        cnt_d   = RELOAD;
        cnt_en  = 1'b1;
      end else if (state_q == W_STALLED) begin
        if (cnt_q == '0) begin
          state_d = W_READY;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_READY;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ready_q  = (state_q == W_READY);
  assign halted_q = (state_q == W_HALTED);
  assign ready_d  = (state_d == W_READY);
  assign halted_d = (state_d == W_HALTED);

  // R3
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == W_HALTED |=> state_q == W_HALTED);

  // R4
  halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit && stall_hit |=> state_q == W_HALTED);

  // R2
  stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hit && !halt_hit && state_q != W_HALTED
    |=> state_q == W_STALLED && cnt_q == RELOAD);

  // R2
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == W_STALLED && !stall_hit && !halt_hit && cnt_q != '0
    |=> state_q == W_STALLED && cnt_q == $past(cnt_q) - 1'b1);

  // R2
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == W_STALLED && !stall_hit && !halt_hit && cnt_q == '0
    |=> state_q == W_READY);

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_WARPS = 2,
  parameter int WARP_W    = 1
) (
  input  logic [WARP_W-1:0]    cur_q,
  input  logic [NUM_WARPS-1:0] ready_d,
  output logic [WARP_W-1:0]    cur_d
);

  // search starts after the current warp and ends on it; nothing ready holds
  always_comb begin
    logic found;
    found = 1'b0;
    cur_d = cur_q;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(cur_q) + k) % NUM_WARPS;
      if (!found && ready_d[idx]) begin
        found = 1'b1;
        cur_d = WARP_W'(idx);
      end
    end
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int NUM_WARPS    = 2,
  parameter int STALL_CYCLES = 4,
  parameter int WARP_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_req,
  input  logic              halt_req,
  input  logic [WARP_W-1:0] req_warp,
  output logic [WARP_W-1:0] cur_warp,
  output logic              issue_valid,
  output logic              done
);

  logic [NUM_WARPS-1:0] ready_q, halted_q, ready_d, halted_d;
  logic [WARP_W-1:0]    cur_q, cur_d;
  logic                 done_q, done_d;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic hit;
    assign hit = (req_warp == WARP_W'(w));
    warp_slot #(.STALL_CYCLES(STALL_CYCLES)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall_hit(stall_req && hit),
      .halt_hit (halt_req && hit),
      .ready_q  (ready_q[w]),
      .halted_q (halted_q[w]),
      .ready_d  (ready_d[w]),
      .halted_d (halted_d[w])
    );
  end

  rr_pick #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W)) u_pick (
    .cur_q  (cur_q),
    .ready_d(ready_d),
    .cur_d  (cur_d)
  );

  assign done_d = &halted_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      done_q <= done_d;
    end
  end

  assign cur_warp    = cur_q;
  assign issue_valid = ready_q[cur_q];
  assign done        = done_q;

  // R8
  done_all_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> &halted_q);

  // R5
  ready_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |ready_q |-> issue_valid);

  // R6
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &ready_d |=> cur_warp != $past(cur_warp));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_d == '0 |=> $stable(cur_warp) && !issue_valid);

endmodule

// File: tb/sim_warp_sched.sv
module sim_warp_sched;

  localparam int CLK_PERIOD = 10;
  localparam int STALL      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stall_req = 1'b0;
  logic       halt_req = 1'b0;
  logic [0:0] req_warp = 1'b0;
  logic [0:0] cur_warp;
  logic       issue_valid;
  logic       done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_sched #(.NUM_WARPS(2), .STALL_CYCLES(STALL)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .halt_req(halt_req),
    .req_warp(req_warp), .cur_warp(cur_warp), .issue_valid(issue_valid),
    .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int c, input int v, input int d);
    check(req, "cur_warp", int'(cur_warp), c);
    check(req, "issue_valid", int'(issue_valid), v);
    check(req, "done", int'(done), d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stall_req = 1'b0; halt_req = 1'b0; req_warp = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // one edge; request driven on the falling edge, outputs sampled after the rising edge
  task automatic step(input logic s, input logic h, input logic w);
    @(negedge clk);
    stall_req = s; halt_req = h; req_warp = w;
    @(posedge clk);
    #1;
    stall_req = 1'b0; halt_req = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    outs("R1", 0, 1, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    step(0, 0, 0); check("R6", "cur after edge1", int'(cur_warp), 1);
    step(0, 0, 0); check("R6", "cur after edge2", int'(cur_warp), 0);
    step(0, 0, 0); check("R6", "cur after edge3", int'(cur_warp), 1);
  endtask

  task automatic t_stall_current();
    do_reset();
    step(1, 0, 0); outs("R5", 1, 1, 0);
    step(0, 0, 0); check("R2", "stalled edge2", int'(cur_warp), 1);
    step(0, 0, 0); check("R2", "stalled edge3", int'(cur_warp), 1);
    step(0, 0, 0); check("R2", "stalled edge4", int'(cur_warp), 1);
    step(0, 0, 0); check("R2", "ready edge5", int'(cur_warp), 0);
    check("R2", "valid edge5", int'(issue_valid), 1);
  endtask

  task automatic t_both_stalled();
    do_reset();
    step(1, 0, 0); outs("R5", 1, 1, 0);
    step(1, 0, 1); outs("R7", 1, 0, 0);
    step(0, 0, 0); outs("R7", 1, 0, 0);
    step(0, 0, 0); outs("R7", 1, 0, 0);
    step(0, 0, 0); outs("R7", 0, 1, 0);
    step(0, 0, 0); outs("R7", 1, 1, 0);
  endtask

  task automatic t_stall_other();
    do_reset();
    step(1, 0, 1); outs("R9", 0, 1, 0);
    step(0, 0, 0); check("R9", "stay edge2", int'(cur_warp), 0);
    step(0, 0, 0); step(0, 0, 0);
    check("R9", "stay edge4", int'(cur_warp), 0);
    step(0, 0, 0); check("R9", "other back edge5", int'(cur_warp), 1);
  endtask

  task automatic t_restall();
    do_reset();
    step(1, 0, 0); check("R10", "cur edge1", int'(cur_warp), 1);
    step(0, 0, 0);
    step(1, 0, 0); check("R10", "cur edge3", int'(cur_warp), 1);
    step(0, 0, 0); step(0, 0, 0);
    check("R10", "still stalled edge5", int'(cur_warp), 1);
    step(0, 0, 0); check("R10", "still stalled edge6", int'(cur_warp), 1);
    step(0, 0, 0); check("R10", "ready edge7", int'(cur_warp), 0);
  endtask

  task automatic t_halt();
    do_reset();
    step(1, 1, 0); outs("R4", 1, 1, 0);
    for (int i = 0; i < STALL + 2; i++) step(0, 0, 0);
    outs("R3", 1, 1, 0);
    step(1, 0, 0); outs("R3", 1, 1, 0);
    for (int i = 0; i < STALL + 1; i++) step(0, 0, 0);
    outs("R3", 1, 1, 0);
    step(0, 1, 1); outs("R8", 1, 0, 1);
    step(0, 0, 0); outs("R8", 1, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_rotate();
    t_stall_current();
    t_both_stalled();
    t_stall_other();
    t_restall();
    t_halt();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule